// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Flag-Gated Acknowledge

This block is the receive half of an I2C slave peripheral. It watches SCL and SDA, which arrive already synchronized to the system clock. It finds START and STOP conditions and shifts each byte in MSB first, sampling on SCL rising edges. The first byte after a START is checked against a programmable 7-bit slave address. When the address matches, that byte and every data byte after it go through a small decision table. The table reads the buffer-full flag and the sticky overflow flag, and from them decides three things for each byte: whether the byte is copied to the holding buffer, whether it is acknowledged, and whether an overflow is recorded.

The CPU side has four controls. It reads the holding buffer through a read strobe, which also clears the buffer-full flag. It clears the overflow flag and the interrupt flag with separate strobes, and it writes the slave address. An interrupt request is raised for every byte handled after an address match, including bytes that were refused. Software therefore learns about a lost byte through the overflow flag, not through a missing interrupt. The acknowledge is an open-drain low drive: the `sda_oe` output asks the pad to pull SDA down.

Top module: `i2cs_rx`

## Requirements
- R1: While `en` is low the block holds its receive state idle, never drives SDA and sets no flag. After `en` rises it does nothing until a START condition (SDA falling while SCL is high).
- R2: Bits are sampled on SCL rising edges, MSB first. On the 8th SCL falling edge after a START, bits [7:1] of the received byte are compared with the 7-bit address register. That register is loaded from `addr_wdata` when `addr_we` is high.
- R3: On an address match, and for every following data byte, if buffer-full=0 and overflow=0 at the 8th SCL falling edge, the byte is copied to `rx_buf`, `buf_full` becomes 1 and an acknowledge is given.
- R4: The acknowledge raises `sda_oe` after the 8th SCL falling edge and drops it after the 9th SCL falling edge, so SDA is low for the whole 9th SCL high phase.
- R5: With buffer-full=0 and overflow=1, the byte is still copied into `rx_buf` and `buf_full` is set, but no acknowledge is given.
- R6: With buffer-full=1, whatever the overflow flag, `rx_buf` keeps its old value, no acknowledge is given and `ovf` is set to 1.
- R7: `irq` is set on the 9th SCL falling edge of every byte handled after an address match, whether or not it was acknowledged. It stays set until `irq_clr`.
- R8: A `buf_rd` strobe clears `buf_full`.
- R9: `ovf` is never cleared by the hardware. Only an `ovf_clr` strobe clears it, and a new overflow in the same cycle wins.
- R10: On an address mismatch there is no acknowledge and no flag change. Every later byte is ignored until the next START.
- R11: A STOP returns the block to idle. A repeated START returns it to address wait. Both reset the bit counter, so a partly received byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Receiver enable |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| addr_we | input | 1 | Write strobe for the slave address |
| addr_wdata | input | DATA_W-1 | New slave address |
| buf_rd | input | 1 | CPU read of the holding buffer; clears buffer-full |
| rx_buf | output | DATA_W | Holding buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| ovf | output | 1 | Sticky overflow flag |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| irq | output | 1 | Interrupt request flag |

## Verification
The assertions check the following on every cycle:
- the acknowledge only starts when both flags were clear, and it only ends right after an SCL falling edge;
- an overflow only appears while the buffer is full;
- a full buffer never changes;
- a read empties the buffer;
- the overflow and interrupt flags stay set until their clear strobes;
- a disabled block never drives SDA.

Only the bench scenarios can show the rest:
- the full four-way decision table walked through in sequence within one transfer;
- that a mismatched address silences the bus until the next START;
- that a repeated START in the middle of a byte realigns the bit counter;
- that a newly written address takes effect.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    typedef struct packed {
        logic load;
        logic ack;
        logic set_ovf;
    } rx_action_t;

    // Per-byte decision from the buffer-full and overflow flags
    function automatic rx_action_t decide(input logic bf, input logic ov);
        rx_action_t a;
        a.load    = !bf;
        a.ack     = !bf && !ov;
        a.set_ovf = bf;
        return a;
    endfunction

endpackage

// File: rtl/i2cs_bus_edge.sv
module i2cs_bus_edge
    import i2cs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.rise  = scl_i && !scl_q;
        evt.fall  = !scl_i && scl_q;
        evt.start = scl_i && scl_q && sda_q && !sda_i;
        evt.stop  = scl_i && scl_q && !sda_q && sda_i;
    end
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
    import i2cs_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  bus_evt_t          evt,
    input  logic              sda_i,
    input  logic [DATA_W-2:0] addr,
    input  rx_action_t        act,
    output logic [DATA_W-1:0] shreg,
    output logic              byte_evt,
    output logic              nine_evt,
    output logic              sda_oe
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W + 1);

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             receiving;
    logic             at_eighth;
    logic             addr_ok;

    always_comb begin
        receiving = (state == ST_ADDR) || (state == ST_DATA);
        at_eighth = receiving && evt.fall && (cnt == CNT_BYTE);
        addr_ok   = (state != ST_ADDR) || (shreg[DATA_W-1:1] == addr);
        byte_evt  = at_eighth && addr_ok;
        nine_evt  = (state == ST_DATA) && evt.fall && (cnt == CNT_ACK);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            sda_oe <= 1'b0;
        end else if (evt.start) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (receiving) begin
            if (evt.rise && (cnt < CNT_BYTE)) begin
                shreg <= {shreg[DATA_W-2:0], sda_i};
                cnt   <= cnt + CNT_W'(1);
            end
            if (at_eighth) begin
                if (addr_ok) begin
                    sda_oe <= act.ack;
                    cnt    <= CNT_ACK;
                    state  <= ST_DATA;
                end else begin
                    cnt    <= '0;
                    state  <= ST_SKIP;
                end
            end
            if (evt.fall && (cnt == CNT_ACK)) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
            end
        end
    end
endmodule

// File: rtl/i2cs_flags.sv
module i2cs_flags
    import i2cs_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_evt,
    input  logic              nine_evt,
    input  logic [DATA_W-1:0] shreg,
    input  logic              buf_rd,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    output rx_action_t        act,
    output logic [DATA_W-1:0] rx_buf,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq
);
    always_comb act = decide(buf_full, ovf);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_buf   <= '0;
            buf_full <= 1'b0;
            ovf      <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (byte_evt && act.load) begin
                rx_buf   <= shreg;
                buf_full <= 1'b1;
            end else if (buf_rd) begin
                buf_full <= 1'b0;
            end
            if (byte_evt && act.set_ovf) ovf <= 1'b1;
            else if (ovf_clr)            ovf <= 1'b0;
            if (nine_evt)     irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cs_rx.sv
module i2cs_rx
    import i2cs_pkg::*;
#(
    parameter int unsigned       DATA_W     = 8,
    parameter logic [DATA_W-2:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_we,
    input  logic [DATA_W-2:0] addr_wdata,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] rx_buf,
    output logic              buf_full,
    input  logic              ovf_clr,
    output logic              ovf,
    input  logic              irq_clr,
    output logic              irq
);
    bus_evt_t          evt;
    rx_action_t        act;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-2:0] addr_q;
    logic              byte_evt;
    logic              nine_evt;

    always_ff @(posedge clk) begin
        if (rst)          addr_q <= RESET_ADDR;
        else if (addr_we) addr_q <= addr_wdata;
    end

    i2cs_bus_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2cs_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .evt      (evt),
        .sda_i    (sda_i),
        .addr     (addr_q),
        .act      (act),
        .shreg    (shreg),
        .byte_evt (byte_evt),
        .nine_evt (nine_evt),
        .sda_oe   (sda_oe)
    );

    i2cs_flags #(.DATA_W(DATA_W)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .byte_evt (byte_evt),
        .nine_evt (nine_evt),
        .shreg    (shreg),
        .buf_rd   (buf_rd),
        .ovf_clr  (ovf_clr),
        .irq_clr  (irq_clr),
        .act      (act),
        .rx_buf   (rx_buf),
        .buf_full (buf_full),
        .ovf      (ovf),
        .irq      (irq)
    );
endmodule

// File: rtl/i2cs_rx_chk.sv
module i2cs_rx_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              buf_rd,
    input logic [DATA_W-1:0] rx_buf,
    input logic              buf_full,
    input logic              ovf_clr,
    input logic              ovf,
    input logic              irq_clr,
    input logic              irq
);
    // R1: a disabled receiver never pulls SDA
    a_r1_quiet_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sda_oe);

    // R3: acknowledge begins only with both flags clear, after SCL went low
    a_r3_ack_flags_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> (!$past(buf_full) && !$past(ovf) && !$past(scl_i)));

    // R4: acknowledge ends right after an SCL falling edge
    a_r4_ack_release: assert property (@(posedge clk) disable iff (rst)
        ($fell(sda_oe) && en && $past(en)) |-> (!$past(scl_i) && $past(scl_i, 2)));

    // R6: overflow only appears while the buffer is full
    a_r6_ovf_needs_full: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(buf_full));

    // R6: a full buffer is never overwritten
    a_r6_buf_hold: assert property (@(posedge clk) disable iff (rst)
        buf_full |=> $stable(rx_buf));

    // R7: interrupt flag holds until cleared
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    // R8: reading a full buffer empties it
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (buf_rd && buf_full) |=> !buf_full);

    // R9: overflow holds until software clears it
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

bind i2cs_rx i2cs_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .buf_rd   (buf_rd),
    .rx_buf   (rx_buf),
    .buf_full (buf_full),
    .ovf_clr  (ovf_clr),
    .ovf      (ovf),
    .irq_clr  (irq_clr),
    .irq      (irq)
);

// File: tb/i2cs_rx_bench.sv
module i2cs_rx_bench;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       addr_we = 1'b0;
    logic [6:0] addr_wdata = '0;
    logic       buf_rd = 1'b0;
    logic [7:0] rx_buf;
    logic       buf_full;
    logic       ovf_clr = 1'b0;
    logic       ovf;
    logic       irq_clr = 1'b0;
    logic       irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2cs_rx u_i2cs_rx (
        .clk(clk), .rst(rst), .en(en), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_we(addr_we), .addr_wdata(addr_wdata),
        .buf_rd(buf_rd), .rx_buf(rx_buf), .buf_full(buf_full),
        .ovf_clr(ovf_clr), .ovf(ovf), .irq_clr(irq_clr), .irq(irq)
    );

    typedef struct packed {
        logic [7:0] data;
        logic       rd_first;
        logic       clr_first;
        logic       ack;
        logic [7:0] buf_v;
        logic       bf;
        logic       ov;
    } vec_t;

    // Walk of the decision table inside one matched transfer
    localparam vec_t VECS [6] = '{
        '{8'hA5, 1'b1, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0},  // R3 both clear
        '{8'h5A, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1},  // R6 full
        '{8'h33, 1'b1, 1'b0, 1'b0, 8'h33, 1'b1, 1'b1},  // R5 empty, ovf
        '{8'hC3, 1'b0, 1'b0, 1'b0, 8'h33, 1'b1, 1'b1},  // R6 full, ovf
        '{8'h81, 1'b1, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0},  // R9 cleared
        '{8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0}   // R3 zero byte
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_rd();
        buf_rd = 1'b1; wait_clk(1); buf_rd = 1'b0; wait_clk(1);
    endtask

    task automatic pulse_irq_clr();
        irq_clr = 1'b1; wait_clk(1); irq_clr = 1'b0; wait_clk(1);
    endtask

    task automatic pulse_ovf_clr();
        ovf_clr = 1'b1; wait_clk(1); ovf_clr = 1'b0; wait_clk(1);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1;   wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl = 1'b0;   wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl = 1'b1;   wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;  wait_clk(Q);
        scl = 1'b1; wait_clk(2 * Q);
        scl = 1'b0; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1;   wait_clk(Q);
        ack = sda_oe;
        wait_clk(Q);
        scl = 1'b0;   wait_clk(Q);
    endtask

    initial begin
        logic ack;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // Reset state
        check("R1 reset sda_oe", sda_oe, 0);
        check("R1 reset buf_full", buf_full, 0);
        check("R9 reset ovf", ovf, 0);
        check("R7 reset irq", irq, 0);
        check("R3 reset rx_buf", rx_buf, 0);

        // R1: disabled block ignores a full addressed byte
        addr_wdata = 7'h3A; addr_we = 1'b1; wait_clk(1); addr_we = 1'b0;
        bus_start();
        send_byte(8'h74, ack);
        check("R1 disabled no ack", ack, 0);
        check("R1 disabled no irq", irq, 0);
        check("R1 disabled no buffer", buf_full, 0);
        bus_stop();
        en = 1'b1; wait_clk(Q);

        // R2/R3/R4/R7: matched address byte (0x3A<<1 | 0)
        bus_start();
        send_byte(8'h74, ack);
        check("R3 address ack", ack, 1);
        check("R4 ack released after 9th fall", sda_oe, 0);
        check("R2 address byte buffered", rx_buf, 8'h74);
        check("R3 buf_full set", buf_full, 1);
        check("R7 irq on address", irq, 1);
        pulse_irq_clr();

        // Table walk through the decision flags
        foreach (VECS[k]) begin
            if (VECS[k].rd_first) pulse_rd();
            if (VECS[k].clr_first) pulse_ovf_clr();
            send_byte(VECS[k].data, ack);
            check($sformatf("R3/R5/R6 vec%0d ack", k), ack, VECS[k].ack);
            check($sformatf("R3/R5/R6 vec%0d rx_buf", k), rx_buf, VECS[k].buf_v);
            check($sformatf("R8 vec%0d buf_full", k), buf_full, VECS[k].bf);
            check($sformatf("R9 vec%0d ovf", k), ovf, VECS[k].ov);
            check($sformatf("R7 vec%0d irq", k), irq, 1);
            pulse_irq_clr();
        end
        bus_stop();

        // R8: read clears buffer-full
        pulse_rd();
        check("R8 read clears buf_full", buf_full, 0);

        // R10: mismatched address, then ignored bytes
        bus_start();
        send_byte(8'h22, ack);
        check("R10 mismatch no ack", ack, 0);
        check("R10 mismatch no irq", irq, 0);
        send_byte(8'h74, ack);
        check("R10 ignored byte no ack", ack, 0);
        check("R10 ignored byte no load", buf_full, 0);
        check("R10 ignored byte no irq", irq, 0);
        bus_stop();

        // R11: repeated START in the middle of a byte realigns the counter
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte(8'h74, ack);
        check("R11 repeated start ack", ack, 1);
        check("R11 repeated start byte", rx_buf, 8'h74);
        bus_stop();
        pulse_rd(); pulse_irq_clr();

        // R2: new address written takes effect
        addr_wdata = 7'h11; addr_we = 1'b1; wait_clk(1); addr_we = 1'b0;
        bus_start();
        send_byte(8'h74, ack);
        check("R2 old address refused", ack, 0);
        bus_start();
        send_byte(8'h23, ack);
        check("R2 new address ack", ack, 1);
        check("R2 new address buffered", rx_buf, 8'h23);
        bus_stop();

        // R9: clear strobe clears ovf after it is set
        send_byte_overflow_check();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Fills the buffer, forces an overflow, then clears it by software
    task automatic send_byte_overflow_check();
        logic ack;
        bus_start();
        send_byte(8'h23, ack);
        check("R6 refused while full", ack, 0);
        check("R6 ovf set", ovf, 1);
        bus_stop();
        wait_clk(Q);
        check("R9 ovf held without clear", ovf, 1);
        pulse_ovf_clr();
        check("R9 ovf cleared by software", ovf, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule